// File: doc/BRIEF.md
# DMA Peripheral Request Source Selector

This block sits in front of a single DMA channel and picks which on-chip peripheral may request transfers on it. A 4-bit select code, a bus-mode bit and a channel enable are the inputs. The selector has five request sources: the transmit-empty and receive-full lines of a plain serial port and of a FIFO serial port, and a timer input-capture event. It passes the chosen source on as one held request line, `dreq`. When the channel is switched on, it takes a copy of the select code and the mode. From that copy it reports a fixed source class and a fixed destination class for the transfer.

Each select code fixes the direction of the transfer. Serial-port codes are only legal in cycle-steal mode. If burst mode is chosen with a serial code, the block raises a configuration-error flag and issues no requests. The held request is withdrawn automatically by pulses from the DMA engine:
- In cycle-steal mode it is withdrawn after every completed transfer.
- In burst mode it is withdrawn only after the last transfer of the block.

For timer captures, several capture sources may have DMA enabled at the same time. Only the highest-priority enabled source is serviced for a capture event, and `cap_grant` reports which one. Clearing both capture-control bits cancels a timer request.

There is no data path through the block, so it has no valid/ready stream. All pins are plain level or single-cycle pulse controls. The DMA engine sees `dreq` as a level that stays high until one of the clear conditions below applies. The block has no back-pressure path: a new source event while `dreq` is already high simply keeps it high.

Top module: `dreq_src_sel`

## Requirements
- R1: After reset, `dreq`, `cap_grant` and `cfg_err` are 0, and `src_cls`/`dst_cls` read 3 (none).
  - On the first cycle `chan_en` is sampled high after being low, the select code and `burst_mode` are captured. From the next cycle, `src_cls`/`dst_cls` show the classes for that code, encoded as 0 external memory, 1 on-chip peripheral, 2 serial data register:
    - code 8: 0→2
    - code 9: 2→0
    - code 10: 0→2
    - code 11: 2→0
    - code 12: 0→0
    - code 13: 0→1
    - code 14: 1→0
- R2: Changes to `sel_code` or `burst_mode` while the channel stays enabled have no effect on the classes, the error flag or which line is routed.
- R3: While enabled, a high sample of the routed line sets `dreq` on the next cycle. The routed line is:
  - code 8: `tx1_req`
  - code 9: `rx1_req`
  - code 10: `tx2_req`
  - code 11: `rx2_req`

  Other serial lines are ignored.
- R4: With a captured serial code (8 to 11) and burst mode, `cfg_err` is 1 from the cycle after capture while the channel stays enabled, and `dreq` stays 0.
- R5: Timer codes (12 to 14) raise no error in either mode. `dreq` is set the cycle after a sample where all of the following hold:
  - `cap_evt` is 1
  - some `cap_dma_en` bit is 1
  - `cap_ctl` is nonzero
- R6: In cycle-steal mode (`burst_mode`=0) a sampled `xfer_done` clears `dreq` on the next cycle.
- R7: In burst mode, `dreq` is cleared only by a sample with both `xfer_done` and `xfer_last` at 1. `xfer_done` alone leaves it set.
- R8: When a timer request is set, `cap_grant` becomes one-hot on the lowest-index set bit of `cap_dma_en`, which is the highest priority. It is 0 whenever `dreq` is 0.
- R9: With a timer code captured, `cap_ctl`=0 clears a pending `dreq` on the next cycle and blocks new timer requests.
- R10: Codes 0 to 7 and 15 route nothing, give classes 3 and never raise `cfg_err`.
- R11: `chan_en` sampled low clears `dreq` and `cap_grant` on the next cycle.
- R12: If a new routed request and a clearing `xfer_done` are sampled in the same cycle, `dreq` stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_en | input | 1 | Channel enable; its rising sample captures the configuration |
| sel_code | input | 4 | Request source select code |
| burst_mode | input | 1 | 1 = burst, 0 = cycle steal |
| tx1_req | input | 1 | Serial port 1 transmit-empty request |
| rx1_req | input | 1 | Serial port 1 receive-full request |
| tx2_req | input | 1 | FIFO serial port transmit-empty request |
| rx2_req | input | 1 | FIFO serial port receive-full request |
| cap_evt | input | 1 | Timer input-capture event |
| cap_dma_en | input | NCAP | Per-source DMA enable for capture; bit 0 has top priority |
| cap_ctl | input | 2 | Timer capture-enable control bits |
| xfer_done | input | 1 | DMA engine: one transfer completed |
| xfer_last | input | 1 | DMA engine: the completed transfer is the last one |
| dreq | output | 1 | Held request to the DMA channel |
| cap_grant | output | NCAP | One-hot capture source being serviced |
| cfg_err | output | 1 | Illegal mode for the captured code |
| src_cls | output | 2 | Source class of the captured code |
| dst_cls | output | 2 | Destination class of the captured code |

## Verification
The failures that matter most are in the captured configuration and in the held request.

A wrong captured code or mode would show up on `src_cls`, `dst_cls` or `cfg_err` one cycle after the enable rises. It would stay visible there for the whole time the channel is on.

A request latch that does not clear on schedule would keep `dreq` high one cycle after the clearing `xfer_done`. A latch that clears too early would drop `dreq` one cycle after a non-final burst transfer. Either fault is visible within a single cycle.

A wrong priority encoding shows on `cap_grant` in the cycle `dreq` rises.

// File: rtl/dsel_pkg.sv
package dsel_pkg;
  localparam int SEL_W = 4;

  typedef enum logic [1:0] {
    CLS_EXT    = 2'd0,
    CLS_PERIPH = 2'd1,
    CLS_SREG   = 2'd2,
    CLS_NONE   = 2'd3
  } cls_e;

  typedef enum logic [1:0] {
    LN_TX1 = 2'd0,
    LN_RX1 = 2'd1,
    LN_TX2 = 2'd2,
    LN_RX2 = 2'd3
  } line_e;

  typedef struct packed {
    logic  valid;
    logic  serial;
    line_e line;
    cls_e  src;
    cls_e  dst;
  } route_t;

  localparam route_t ROUTE_IDLE = '{valid: 1'b0, serial: 1'b0, line: LN_TX1,
                                    src: CLS_NONE, dst: CLS_NONE};

  function automatic route_t decode_sel(input logic [SEL_W-1:0] code);
    route_t r;
    r = ROUTE_IDLE;
    case (code)
      4'b1000: r = '{valid: 1'b1, serial: 1'b1, line: LN_TX1, src: CLS_EXT,    dst: CLS_SREG};
      4'b1001: r = '{valid: 1'b1, serial: 1'b1, line: LN_RX1, src: CLS_SREG,   dst: CLS_EXT};
      4'b1010: r = '{valid: 1'b1, serial: 1'b1, line: LN_TX2, src: CLS_EXT,    dst: CLS_SREG};
      4'b1011: r = '{valid: 1'b1, serial: 1'b1, line: LN_RX2, src: CLS_SREG,   dst: CLS_EXT};
      4'b1100: r = '{valid: 1'b1, serial: 1'b0, line: LN_TX1, src: CLS_EXT,    dst: CLS_EXT};
      4'b1101: r = '{valid: 1'b1, serial: 1'b0, line: LN_TX1, src: CLS_EXT,    dst: CLS_PERIPH};
      4'b1110: r = '{valid: 1'b1, serial: 1'b0, line: LN_TX1, src: CLS_PERIPH, dst: CLS_EXT};
      default: r = ROUTE_IDLE;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/dsel_cfg.sv
// Captures the select code and bus mode on the rising sample of the enable.
module dsel_cfg
  import dsel_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chan_en,
  input  logic [SEL_W-1:0] sel_code,
  input  logic             burst_mode,
  output logic             active,
  output route_t           route,
  output logic             burst
);
  logic en_rise;
  assign en_rise = chan_en & ~active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      route  <= ROUTE_IDLE;
      burst  <= 1'b0;
    end else begin
      active <= chan_en;
      if (en_rise) begin
        route <= decode_sel(sel_code);
        burst <= burst_mode;
      end
    end
  end
endmodule

// File: rtl/dsel_route.sv
// Picks the request line, checks mode legality and ranks capture sources.
module dsel_route
  import dsel_pkg::*;
#(
  parameter int NCAP = 3
) (
  input  logic            active,
  input  logic            chan_en,
  input  route_t          route,
  input  logic            burst,
  input  logic            tx1_req,
  input  logic            rx1_req,
  input  logic            tx2_req,
  input  logic            rx2_req,
  input  logic            cap_evt,
  input  logic [NCAP-1:0] cap_dma_en,
  input  logic [1:0]      cap_ctl,
  output logic            fire,
  output logic [NCAP-1:0] fire_grant,
  output logic            cancel,
  output logic            cfg_err
);
  logic [3:0] lines;
  logic       serial_raw, timer_sel, cap_live, timer_raw, raw;

  assign lines      = {rx2_req, tx2_req, rx1_req, tx1_req};
  assign serial_raw = lines[route.line];
  assign timer_sel  = route.valid & ~route.serial;
  assign cap_live   = |cap_ctl;
  assign timer_raw  = cap_evt & (|cap_dma_en) & cap_live;
  assign raw        = route.serial ? serial_raw : timer_raw;

  assign cfg_err = active & route.serial & burst;
  assign fire    = active & chan_en & route.valid & ~cfg_err & raw;
  assign cancel  = timer_sel & ~cap_live;

  // Fixed priority: lowest index wins; seen[i] marks any enabled source below i.
  logic [NCAP:0] seen;
  assign seen[0] = 1'b0;
  for (genvar i = 0; i < NCAP; i++) begin : g_rank
    assign seen[i+1]     = seen[i] | cap_dma_en[i];
    assign fire_grant[i] = timer_sel & cap_dma_en[i] & ~seen[i];
  end
endmodule

// File: rtl/dsel_hold.sv
// Holds the request until the mode-dependent clear condition.
module dsel_hold #(
  parameter int NCAP = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            chan_en,
  input  logic            fire,
  input  logic [NCAP-1:0] fire_grant,
  input  logic            cancel,
  input  logic            burst,
  input  logic            xfer_done,
  input  logic            xfer_last,
  output logic            dreq,
  output logic [NCAP-1:0] cap_grant
);
  logic clr;
  assign clr = cancel | (xfer_done & (~burst | xfer_last));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dreq      <= 1'b0;
      cap_grant <= '0;
    end else if (!chan_en) begin
      dreq      <= 1'b0;
      cap_grant <= '0;
    end else if (fire) begin
      dreq      <= 1'b1;
      cap_grant <= fire_grant;
    end else if (clr) begin
      dreq      <= 1'b0;
      cap_grant <= '0;
    end
  end
endmodule

// File: rtl/dreq_src_sel.sv
module dreq_src_sel
  import dsel_pkg::*;
#(
  parameter int NCAP = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            chan_en,
  input  logic [3:0]      sel_code,
  input  logic            burst_mode,
  input  logic            tx1_req,
  input  logic            rx1_req,
  input  logic            tx2_req,
  input  logic            rx2_req,
  input  logic            cap_evt,
  input  logic [NCAP-1:0] cap_dma_en,
  input  logic [1:0]      cap_ctl,
  input  logic            xfer_done,
  input  logic            xfer_last,
  output logic            dreq,
  output logic [NCAP-1:0] cap_grant,
  output logic            cfg_err,
  output logic [1:0]      src_cls,
  output logic [1:0]      dst_cls
);
  logic            active, burst_q, fire, cancel;
  route_t          route;
  logic [NCAP-1:0] fire_grant;

  dsel_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .sel_code(sel_code),
    .burst_mode(burst_mode), .active(active), .route(route), .burst(burst_q)
  );

  dsel_route #(.NCAP(NCAP)) u_route (
    .active(active), .chan_en(chan_en), .route(route), .burst(burst_q),
    .tx1_req(tx1_req), .rx1_req(rx1_req), .tx2_req(tx2_req), .rx2_req(rx2_req),
    .cap_evt(cap_evt), .cap_dma_en(cap_dma_en), .cap_ctl(cap_ctl),
    .fire(fire), .fire_grant(fire_grant), .cancel(cancel), .cfg_err(cfg_err)
  );

  dsel_hold #(.NCAP(NCAP)) u_hold (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .fire(fire),
    .fire_grant(fire_grant), .cancel(cancel), .burst(burst_q),
    .xfer_done(xfer_done), .xfer_last(xfer_last),
    .dreq(dreq), .cap_grant(cap_grant)
  );

  assign src_cls = route.src;
  assign dst_cls = route.dst;
endmodule

// File: rtl/dsel_chk.sv
module dsel_chk #(
  parameter int NCAP = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            chan_en,
  input logic            active,
  input logic            burst_q,
  input logic [1:0]      cap_ctl,
  input logic            xfer_done,
  input logic            xfer_last,
  input logic            dreq,
  input logic [NCAP-1:0] cap_grant,
  input logic            cfg_err,
  input logic [1:0]      src_cls,
  input logic [1:0]      dst_cls
);
  // R4: an illegal mode never coexists with a request
  a_r4_err_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !dreq);

  // R11: disabling the channel withdraws the request
  a_r11_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> !dreq);

  // R8: at most one capture source granted, and only with a request
  a_r8_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cap_grant));
  a_r8_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    (|cap_grant) |-> dreq);

  // R2: classes frozen while the channel stays on
  a_r2_cls_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && active) |=> ($stable(src_cls) && $stable(dst_cls)));

  // R7: burst request survives anything but a final transfer
  a_r7_burst_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dreq && burst_q && chan_en && (|cap_ctl) && !(xfer_done && xfer_last)) |=> dreq);
endmodule

bind dreq_src_sel dsel_chk #(.NCAP(NCAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .active(active),
  .burst_q(burst_q), .cap_ctl(cap_ctl), .xfer_done(xfer_done),
  .xfer_last(xfer_last), .dreq(dreq), .cap_grant(cap_grant),
  .cfg_err(cfg_err), .src_cls(src_cls), .dst_cls(dst_cls)
);

// File: tb/sim_dreq_src_sel.sv
`timescale 1ns/1ps
module sim_dreq_src_sel;
  localparam int NCAP = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chan_en = 1'b0, burst_mode = 1'b0;
  logic [3:0] sel_code = 4'd0;
  logic tx1_req = 1'b0, rx1_req = 1'b0, tx2_req = 1'b0, rx2_req = 1'b0;
  logic cap_evt = 1'b0, xfer_done = 1'b0, xfer_last = 1'b0;
  logic [NCAP-1:0] cap_dma_en = '0;
  logic [1:0] cap_ctl = 2'd0;
  logic dreq, cfg_err;
  logic [NCAP-1:0] cap_grant;
  logic [1:0] src_cls, dst_cls;

  always #10 clk = ~clk;  // 50 MHz

  dreq_src_sel #(.NCAP(NCAP)) u0 (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .sel_code(sel_code),
    .burst_mode(burst_mode), .tx1_req(tx1_req), .rx1_req(rx1_req),
    .tx2_req(tx2_req), .rx2_req(rx2_req), .cap_evt(cap_evt),
    .cap_dma_en(cap_dma_en), .cap_ctl(cap_ctl), .xfer_done(xfer_done),
    .xfer_last(xfer_last), .dreq(dreq), .cap_grant(cap_grant),
    .cfg_err(cfg_err), .src_cls(src_cls), .dst_cls(dst_cls)
  );

  int checks = 0, errors = 0;
  string phase = "R1";
  bit done_flag = 0;

  // Behavioural reference state
  bit m_en_q = 0, m_burst = 0, m_req = 0;
  int m_sel = 0;
  logic [NCAP-1:0] m_grant = '0;

  function automatic int cls_src(int c);
    case (c)
      8, 10, 12, 13: return 0;
      9, 11: return 2;
      14: return 1;
      default: return 3;
    endcase
  endfunction
  function automatic int cls_dst(int c);
    case (c)
      8, 10: return 2;
      9, 11, 12, 14: return 0;
      13: return 1;
      default: return 3;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en_q = 0; m_burst = 0; m_req = 0; m_sel = 0; m_grant = '0;
    end else begin
      bit is_ser, is_tmr, err, raw, fire, cancel, clr;
      logic [NCAP-1:0] pick;
      is_ser = (m_sel >= 8 && m_sel <= 11);
      is_tmr = (m_sel >= 12 && m_sel <= 14);
      err = m_en_q && is_ser && m_burst;
      case (m_sel)
        8: raw = tx1_req;
        9: raw = rx1_req;
        10: raw = tx2_req;
        11: raw = rx2_req;
        12, 13, 14: raw = cap_evt && (cap_dma_en != 0) && (cap_ctl != 0);
        default: raw = 0;
      endcase
      pick = '0;
      if (is_tmr) begin
        for (int i = NCAP-1; i >= 0; i--) if (cap_dma_en[i]) begin pick = '0; pick[i] = 1'b1; end
      end
      fire = m_en_q && chan_en && (is_ser || is_tmr) && !err && raw;
      cancel = is_tmr && (cap_ctl == 0);
      clr = cancel || (xfer_done && (!m_burst || xfer_last));
      if (!chan_en) begin m_req = 0; m_grant = '0; end
      else if (fire) begin m_req = 1; m_grant = pick; end
      else if (clr) begin m_req = 0; m_grant = '0; end
      if (chan_en && !m_en_q) begin m_sel = sel_code; m_burst = burst_mode; end
      m_en_q = chan_en;
    end
  end

  task automatic cmp(string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", phase, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      bit exp_err;
      exp_err = m_en_q && (m_sel >= 8 && m_sel <= 11) && m_burst;
      cmp("dreq", dreq, m_req);
      cmp("cap_grant", cap_grant, m_grant);
      cmp("cfg_err", cfg_err, exp_err);
      cmp("src_cls", src_cls, cls_src(m_sel));
      cmp("dst_cls", dst_cls, cls_dst(m_sel));
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #4;
  endtask
  task automatic set_line(int k, logic v);
    case (k)
      0: tx1_req = v;
      1: rx1_req = v;
      2: tx2_req = v;
      default: rx2_req = v;
    endcase
  endtask
  task automatic pulse_line(int k);
    set_line(k, 1'b1); step(1); set_line(k, 1'b0);
  endtask
  task automatic pulse_evt();
    cap_evt = 1'b1; step(1); cap_evt = 1'b0;
  endtask
  task automatic pulse_done(logic last);
    xfer_done = 1'b1; xfer_last = last; step(1); xfer_done = 1'b0; xfer_last = 1'b0;
  endtask
  task automatic open_chan(int code, logic bm);
    chan_en = 1'b0; step(2);
    sel_code = 4'(code); burst_mode = bm; chan_en = 1'b1; step(2);
  endtask

  task automatic finish_run();
    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    phase = "R1"; step(1);
    checks++;
    if (dreq !== 1'b0 || src_cls !== 2'd3 || dst_cls !== 2'd3 || cfg_err !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: actual %0d/%0d/%0d/%0d expected 0/3/3/0", dreq, src_cls, dst_cls, cfg_err);
    end
    step(1);
    // R3 routing and R6 per-transfer clear, every serial code
    for (int c = 8; c <= 11; c++) begin
      phase = "R3";
      open_chan(c, 1'b0);
      pulse_line((c - 7) % 4); step(2);  // wrong line ignored
      pulse_line(c - 8); step(2);
      phase = "R6";
      pulse_done(1'b0); step(2);
    end
    // R12: new request coincides with a clearing done
    phase = "R12";
    open_chan(8, 1'b0);
    pulse_line(0); step(1);
    tx1_req = 1'b1; xfer_done = 1'b1; step(1); tx1_req = 1'b0; xfer_done = 1'b0;
    step(2); pulse_done(1'b0); step(1);
    // R2: config changes while enabled are ignored
    phase = "R2";
    sel_code = 4'd12; burst_mode = 1'b1; step(3);
    pulse_line(0); step(2); pulse_done(1'b0); step(1);
    // R4: serial + burst is illegal
    phase = "R4";
    open_chan(10, 1'b1); step(1);
    pulse_line(2); step(3);
    // R5/R7: timer code in burst mode
    phase = "R7";
    cap_ctl = 2'b01; cap_dma_en = 3'b110;
    open_chan(13, 1'b1);
    pulse_evt(); step(2);
    pulse_done(1'b0); step(2);
    pulse_done(1'b0); step(2);
    pulse_done(1'b1); step(2);
    phase = "R5";
    open_chan(14, 1'b0);
    pulse_evt(); step(2); pulse_done(1'b0); step(2);
    open_chan(12, 1'b0);
    pulse_evt(); step(2); pulse_done(1'b0); step(2);
    // R8: priority among capture sources
    phase = "R8";
    cap_dma_en = 3'b101; pulse_evt(); step(2); pulse_done(1'b0); step(1);
    cap_dma_en = 3'b100; pulse_evt(); step(2); pulse_done(1'b0); step(1);
    cap_dma_en = 3'b000; pulse_evt(); step(2);
    // R9: capture control bits cleared cancels
    phase = "R9";
    cap_dma_en = 3'b011;
    pulse_evt(); step(2);
    cap_ctl = 2'b00; step(2);
    pulse_evt(); step(2);
    cap_ctl = 2'b10; pulse_evt(); step(2); pulse_done(1'b0); step(1);
    // R10: unused codes do nothing
    phase = "R10";
    open_chan(15, 1'b1);
    tx1_req = 1; rx1_req = 1; tx2_req = 1; rx2_req = 1; cap_evt = 1; step(2);
    tx1_req = 0; rx1_req = 0; tx2_req = 0; rx2_req = 0; cap_evt = 0; step(1);
    open_chan(0, 1'b0); pulse_line(0); pulse_evt(); step(2);
    open_chan(7, 1'b1); pulse_line(3); step(2);
    // R11: disabling clears a pending request
    phase = "R11";
    open_chan(12, 1'b0);
    pulse_evt(); step(2);
    chan_en = 1'b0; step(3);
    open_chan(9, 1'b0);
    pulse_line(1); step(1);
    chan_en = 1'b0; step(3);
    finish_run();
  end
endmodule